// File: doc/BRIEF.md
# Four-Channel DAC Frame Writer

This block turns a short command list into serial frames for a four-channel DAC. The list arrives one byte at a time over a valid/ready stream. The first byte is a pair count. Each pair that follows is a data byte and then a channel byte. For each pair the block builds a two-byte frame and passes the bytes one at a time to an external SPI shift engine over a request/accept/complete handshake. The DAC's active-low sync line frames each pair: it falls before the first byte and rises once the second byte has been shifted out.

The controller is a single state machine:

- IDLE accepts the count. A zero count goes to FINISH; any other count goes to GET_DATA.
- GET_DATA and GET_CHAN accept the two bytes of a pair.
- SYNC_SETUP drives sync low for one cycle with no request.
- SEND_HI offers the first byte until it is accepted, then goes to WAIT_HI.
- WAIT_HI waits for the engine's completion pulse, then goes to SEND_LO.
- SEND_LO and WAIT_LO do the same for the second byte, then go to GAP.
- GAP holds sync high for a set number of cycles. It then goes to FINISH if that pair was the last one, and to GET_DATA otherwise.
- FINISH pulses done for one cycle and returns to IDLE.

Top module: `dac_frame_writer`

## Requirements
- R1: The input stream is a count byte N followed by N pairs, each a data byte then a channel byte. A byte is taken on a clock where in_valid and in_ready are both high, and in_ready is high only in IDLE, GET_DATA and GET_CHAN.
- R2: Only bits 1:0 of the channel byte select the channel (0 to 3). Bits 7:2 have no effect on the frame.
- R3: The first frame byte carries the channel in bits 7:6, 0 in bit 5, 1 in bit 4 (update at once) and data bits 7:4 in bits 3:0.
- R4: The second frame byte carries data bits 3:0 in bits 7:4, with bits 3:0 at zero.
- R5: dac_sync_n falls at least one clock before the first byte request of a frame. It stays low through both bytes until the second byte's spi_done, then rises. Exactly two bytes are sent while it is low.
- R6: A byte request holds spi_req_valid and spi_req_byte steady until spi_req_ready. No further request is made until spi_done for the accepted byte.
- R7: Pairs are sent strictly in input order, one frame per pair. No input byte is accepted while dac_sync_n is low.
- R8: Between consecutive frames, dac_sync_n stays high for at least GAP_CYC clocks.
- R9: A count of zero sends no frames, gives a done pulse and returns to IDLE.
- R10: After the last frame's sync rise, done is high for exactly one clock, with dac_sync_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte (count, data or channel) |
| spi_req_valid | output | 1 | Frame byte offered to the SPI engine |
| spi_req_ready | input | 1 | SPI engine accepts the offered byte |
| spi_req_byte | output | 8 | Frame byte to shift out |
| spi_done | input | 1 | One-clock pulse when the accepted byte has been shifted |
| dac_sync_n | output | 1 | Active-low DAC frame sync |
| done | output | 1 | One-clock pulse when a command list is finished |

## Verification
The bench builds the block with GAP_CYC set to 2. This makes the gap timer count over more than one cycle, so the minimum high time of sync between frames is measured against a window wider than a single state. It runs a zero count, single pairs and a list of several pairs whose channel bytes have set upper bits. It also varies the engine's accept stall and shift latency, so the request hold and the wait for completion are both exercised.

// File: rtl/dacfw_pkg.sv
package dacfw_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GET_DATA,
        ST_GET_CHAN,
        ST_SYNC_SETUP,
        ST_SEND_HI,
        ST_WAIT_HI,
        ST_SEND_LO,
        ST_WAIT_LO,
        ST_GAP,
        ST_FINISH
    } dacfw_state_e;
endpackage

// File: rtl/dacfw_pack.sv
module dacfw_pack
    import dacfw_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic [BYTE_W-1:0] value,
    input  logic [CH_W-1:0]   chan,
    output logic [BYTE_W-1:0] hi_byte,
    output logic [BYTE_W-1:0] lo_byte
);
    localparam int PAD_W = BYTE_W - CH_W - 1 - NIB_W;

    // channel on top, one padding bit, update flag, upper data nibble
    assign hi_byte = {chan, {PAD_W{1'b0}}, 1'b1, value[BYTE_W-1:NIB_W]};
    // lower data nibble left-justified
    assign lo_byte = {value[NIB_W-1:0], {NIB_W{1'b0}}};
endmodule

// File: rtl/dacfw_gap_timer.sv
module dacfw_gap_timer #(
    parameter int GAP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int GCW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [GCW-1:0] LAST_VAL = GCW'(GAP_CYC - 1);

    logic [GCW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q != LAST_VAL) cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == LAST_VAL);
endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
    import dacfw_pkg::*;
#(
    parameter int CH_W    = 2,
    parameter int GAP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              spi_req_valid,
    input  logic              spi_req_ready,
    output logic [BYTE_W-1:0] spi_req_byte,
    input  logic              spi_done,
    output logic              dac_sync_n,
    output logic              done
);
    dacfw_state_e state_q, state_d;
    logic [BYTE_W-1:0] remain_q;
    logic [BYTE_W-1:0] value_q;
    logic [CH_W-1:0]   chan_q;
    logic [BYTE_W-1:0] hi_byte, lo_byte;
    logic              gap_last;
    logic              take;

    assign take = in_valid && in_ready;

    dacfw_pack #(.CH_W(CH_W)) u_pack (
        .value   (value_q),
        .chan    (chan_q),
        .hi_byte (hi_byte),
        .lo_byte (lo_byte)
    );

    dacfw_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_GAP),
        .last  (gap_last)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (take) state_d = (in_data == '0) ? ST_FINISH : ST_GET_DATA;
            ST_GET_DATA:   if (take) state_d = ST_GET_CHAN;
            ST_GET_CHAN:   if (take) state_d = ST_SYNC_SETUP;
            ST_SYNC_SETUP: state_d = ST_SEND_HI;
            ST_SEND_HI:    if (spi_req_ready) state_d = ST_WAIT_HI;
            ST_WAIT_HI:    if (spi_done) state_d = ST_SEND_LO;
            ST_SEND_LO:    if (spi_req_ready) state_d = ST_WAIT_LO;
            ST_WAIT_LO:    if (spi_done) state_d = ST_GAP;
            ST_GAP:        if (gap_last) state_d = (remain_q == 1) ? ST_FINISH : ST_GET_DATA;
            ST_FINISH:     state_d = ST_IDLE;
        endcase
    end

    // state register and captured command fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            value_q  <= '0;
            chan_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && take)     remain_q <= in_data;
            if (state_q == ST_GAP && gap_last)  remain_q <= remain_q - 1'b1;
            if (state_q == ST_GET_DATA && take) value_q <= in_data;
            if (state_q == ST_GET_CHAN && take) chan_q <= in_data[CH_W-1:0];
        end
    end

    // outputs decoded from state
    always_comb begin
        in_ready      = 1'b0;
        spi_req_valid = 1'b0;
        spi_req_byte  = '0;
        dac_sync_n    = 1'b1;
        done          = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GET_DATA, ST_GET_CHAN: in_ready = 1'b1;
            ST_SYNC_SETUP: dac_sync_n = 1'b0;
            ST_SEND_HI: begin
                dac_sync_n    = 1'b0;
                spi_req_valid = 1'b1;
                spi_req_byte  = hi_byte;
            end
            ST_WAIT_HI: dac_sync_n = 1'b0;
            ST_SEND_LO: begin
                dac_sync_n    = 1'b0;
                spi_req_valid = 1'b1;
                spi_req_byte  = lo_byte;
            end
            ST_WAIT_LO: dac_sync_n = 1'b0;
            ST_GAP:     dac_sync_n = 1'b1;
            ST_FINISH:  done = 1'b1;
        endcase
    end

    a_r5_req_under_sync: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req_valid |-> !dac_sync_n);

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req_valid && !spi_req_ready) |=> (spi_req_valid && $stable(spi_req_byte)));

    a_r7_no_input_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_sync_n |-> !in_ready);

    a_r10_done_sync_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> dac_sync_n);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/tb_dac_frame_writer.sv
module tb_dac_frame_writer;
    localparam int CLK_PERIOD = 10;
    localparam int GAP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       spi_req_valid;
    logic       spi_req_ready = 1'b1;
    logic [7:0] spi_req_byte;
    logic       spi_done = 1'b0;
    logic       dac_sync_n;
    logic       done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_frame_writer #(.CH_W(2), .GAP_CYC(GAP)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .spi_req_valid(spi_req_valid), .spi_req_ready(spi_req_ready),
        .spi_req_byte(spi_req_byte), .spi_done(spi_done),
        .dac_sync_n(dac_sync_n), .done(done)
    );

    int nchecks = 0;
    int nerr = 0;
    int done_cnt = 0;
    logic [7:0] exp_q[$];
    int stall_k = 0;
    int lat = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // behavioural model of the SPI engine plus per-clock comparison
    bit busy = 0;
    int dly = 0;
    int hold = 0;
    int frame_bytes = 0;
    int high_cnt = 0;
    bit seen_frame = 0;
    bit sync_prev = 1;
    logic [7:0] last_byte = '0;
    bit was_stalled = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            spi_done = 1'b0;
            if (!sync_prev && dac_sync_n) begin
                chk(frame_bytes == 2, "R5 bytes per frame", frame_bytes, 2);
                high_cnt = 0;
            end
            if (sync_prev && !dac_sync_n) begin
                if (seen_frame) chk(high_cnt >= GAP, "R8 sync gap", high_cnt, GAP);
                frame_bytes = 0;
                seen_frame = 1;
            end
            if (dac_sync_n) high_cnt++;
            if (done) begin
                done_cnt++;
                chk(dac_sync_n && sync_prev, "R10 done with sync high", dac_sync_n, 1);
                chk(exp_q.size() == 0, "R9 R10 all frames sent before done", exp_q.size(), 0);
            end
            if (busy) begin
                chk(!spi_req_valid, "R6 no request before completion", spi_req_valid, 0);
                if (dly == 0) begin
                    spi_done = 1'b1;
                    busy = 0;
                end else dly--;
            end else if (spi_req_valid) begin
                if (was_stalled)
                    chk(spi_req_byte == last_byte, "R6 byte stable while stalled", spi_req_byte, last_byte);
                if (hold < stall_k) begin
                    spi_req_ready = 1'b0;
                    hold++;
                    was_stalled = 1;
                    last_byte = spi_req_byte;
                end else begin
                    spi_req_ready = 1'b1;
                    hold = 0;
                    was_stalled = 0;
                    if (frame_bytes == 0)
                        chk(!sync_prev, "R5 sync low before first byte", sync_prev, 0);
                    if (exp_q.size() == 0) begin
                        chk(0, "R7 R9 unexpected byte", spi_req_byte, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(spi_req_byte == e, frame_bytes == 0 ? "R3 R7 first byte" : "R4 R7 second byte",
                            spi_req_byte, e);
                    end
                    frame_bytes++;
                    busy = 1;
                    dly = lat;
                end
            end
            sync_prev = dac_sync_n;
        end
    end

    task automatic push_in(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        in_valid = 1'b1;
        in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    logic [7:0] pd[8];
    logic [7:0] pc[8];

    task automatic run_list(input int n, input int gap);
        int target;
        target = done_cnt + 1;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({pc[i][1:0], 1'b0, 1'b1, pd[i][7:4]});
            exp_q.push_back({pd[i][3:0], 4'b0000});
        end
        push_in(n[7:0], gap);
        for (int i = 0; i < n; i++) begin
            push_in(pd[i], gap);
            push_in(pc[i], gap);
        end
        while (done_cnt < target) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(done_cnt == target, "R1 R10 one done per list", done_cnt, target);
        chk(exp_q.size() == 0, "R7 every pair framed", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchecks++;
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dac_sync_n == 1'b1, "R5 reset sync high", dac_sync_n, 1);
        chk(spi_req_valid == 1'b0, "R6 reset no request", spi_req_valid, 0);
        chk(done == 1'b0, "R10 reset no done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 idle ready", in_ready, 1);

        // R9: zero count
        run_list(0, 0);

        // single pair, channel 1
        pd[0] = 8'hA5; pc[0] = 8'h01;
        run_list(1, 0);

        // R2: upper channel bits ignored, extremes of data, engine latency
        lat = 3;
        pd[0] = 8'hFF; pc[0] = 8'hFE;
        pd[1] = 8'h00; pc[1] = 8'hFF;
        pd[2] = 8'h3C; pc[2] = 8'h7C;
        run_list(3, 0);

        // R6: accept stalls, gaps on the input stream
        stall_k = 2; lat = 0;
        for (int i = 0; i < 5; i++) begin
            pd[i] = 8'(8'h11 * (i + 3));
            pc[i] = 8'(i * 8'h45);
        end
        run_list(5, 2);

        // zero count again after traffic
        stall_k = 0;
        run_list(0, 1);

        finish_run();
    end
endmodule